// File: doc/BRIEF.md
# Block Write-Protection and Status Unit

This unit sits beside the serial command decoder of a small non-volatile memory. It owns the 8-bit status byte and, for every write request the decoder presents, decides in the same cycle whether the write may go ahead. A request is either a data-array write at a byte address or a status write carrying a new status byte. The decision depends on the write-enable latch, the busy state of the programming engine, two block-protect bits, a status-lock bit and an external write-protect pin.

The protected part of the array is the top quarter, the top half or all of it, chosen by the two block-protect bits. The counter area at the bottom of the array is never covered by that region, because a separate comparison rule guards it. When the status-lock bit is set and the pin is low, status writes are refused. Raising the pin lifts this lock and leaves the block-protect bits unchanged. The non-volatile bits are modelled as flops with reset values. While a programming cycle runs, their readback stays frozen. The latch and busy bits are always shown live.

Top module: `wps_status_unit`

## Requirements
- R1: After reset, with `wel_i` and `busy_i` low, `status_o` reads 0x10: only bit 4 (comparison flag) is set.
- R2: The block-protect field is status bits 3:2. It guards addresses as follows: 00 guards nothing; 01 guards 0x300 to 0x3FF; 10 guards 0x200 to 0x3FF; 11 guards 0x000 to 0x3FF. An array write to a guarded address gives `allow_o` = 0.
- R3: Array writes to 0x000 to 0x01F are never refused because of the block-protect bits.
- R4: `allow_o` is 1 only while `req_valid_i` is 1, `wel_i` is 1 and `busy_i` is 0. This applies to both request kinds.
- R5: An allowed status write changes only bit 7 (status lock) and bits 3:2 (block protect). Bits 6, 5, 4, 1 and 0 of the written byte have no effect. Bit 5 always reads 0.
- R6: While bit 7 is 1 and `wp_pin_i` is 0, status writes are refused. Raising the pin lets them through again and leaves bits 3:2 unchanged. The pin is active high, and an undriven pin must be pulled to 0 on the board.
- R7: While bit 7 is 0, status writes need only the latch and an idle engine, whatever the pin level.
- R8: A status write that is allowed takes effect at the clock edge that ends the request cycle. Bits 7, 3:2 of `status_o` show the new value two cycles after the request, provided `busy_i` is 0 in the cycle after the request. While `busy_i` is 1 those readback bits hold. They load one cycle after `busy_i` returns to 0.
- R9: `status_o` bit 1 equals `wel_i` and bit 0 equals `busy_i` in the same cycle.
- R10: A pulse on `cmp_valid_i` loads `cmp_lower_i` into status bit 4, which is visible in the next cycle. Bit 6 (erased flag) keeps its reset value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_pin_i | input | 1 | Write-protect pin level, active high |
| req_valid_i | input | 1 | A write request is presented this cycle |
| req_kind_i | input | 1 | 0 = array write, 1 = status write |
| req_addr_i | input | 10 | Byte address of an array write |
| req_data_i | input | 8 | New status byte for a status write |
| wel_i | input | 1 | Write-enable latch state |
| busy_i | input | 1 | Programming cycle in progress |
| cmp_valid_i | input | 1 | Counter comparison result is valid |
| cmp_lower_i | input | 1 | Counter comparison found the new value lower |
| allow_o | output | 1 | Request may proceed (combinational) |
| status_o | output | 8 | Status byte for readback |

## Verification
The decision on `allow_o` is combinational, so the bench samples it one time unit after it drives a request on the falling edge, within the same cycle. Status writes commit at the next rising edge and reach the frozen readback one edge later. The bench therefore reads bits 7 and 3:2 two falling edges after the request. Bits 1:0 are sampled in the same cycle they are driven, and bit 4 one edge after the comparison pulse. For the freeze case, the bench raises `busy_i` in the cycle after the request, holds it for several cycles and checks the old value throughout. It then expects the new value at the first falling edge after one idle cycle.

// File: rtl/wps_pkg.sv
// Package: shared types and bit positions of the status byte.
// Assumes an 8-bit status byte with the lock bit at 7 and protect bits at 3:2.
package wps_pkg;

    typedef enum logic {
        WR_ARRAY  = 1'b0,
        WR_STATUS = 1'b1
    } wr_kind_e;

    // Non-volatile part of the status byte that a status write may change.
    typedef struct packed {
        logic       lock;
        logic [1:0] bp;
    } nv_bits_t;

    localparam int SR_W        = 8;
    localparam int SR_LOCK_POS = 7;
    localparam int SR_ERA_POS  = 6;
    localparam int SR_CMP_POS  = 4;
    localparam int SR_BP_HI    = 3;
    localparam int SR_BP_LO    = 2;
    localparam int SR_WEL_POS  = 1;
    localparam int SR_BSY_POS  = 0;

endpackage

// File: rtl/wps_region_dec.sv
// Region decoder: tells whether an array address falls in the region
// guarded by the block-protect bits. The counter area at the bottom of
// the array is exempt. Assumes ADDR_W >= 3 and CNT_BYTES below a quarter
// of the array.
module wps_region_dec #(
    parameter int ADDR_W    = 10,
    parameter int CNT_BYTES = 32
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              guarded_o
);
    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] CNT_LIMIT = ADDR_W'(CNT_BYTES);

    logic in_range;
    logic in_counter;

    // Compare the address against the lower bound chosen by the protect bits.
    always_comb begin
        unique case (bp_i)
            2'b00:   in_range = 1'b0;
            2'b01:   in_range = (addr_i >= QTR_BASE);
            2'b10:   in_range = (addr_i >= HALF_BASE);
            default: in_range = 1'b1;
        endcase
    end

    // Exempt the counter area only if the parameters define one.
    generate
        if (CNT_BYTES > 0) begin : g_cnt
            assign in_counter = (addr_i < CNT_LIMIT);
        end else begin : g_nocnt
            assign in_counter = 1'b0;
        end
    endgenerate

    assign guarded_o = in_range && !in_counter;

endmodule

// File: rtl/wps_gate.sv
// Write gate: combines the enable latch, busy state, region guard and the
// status lock (lock bit plus pin) into a single allow decision for the
// request presented this cycle. Purely combinational.
module wps_gate
    import wps_pkg::*;
(
    input  logic     req_valid_i,
    input  wr_kind_e kind_i,
    input  logic     wel_i,
    input  logic     busy_i,
    input  logic     guarded_i,
    input  logic     lock_bit_i,
    input  logic     wp_pin_i,
    output logic     allow_o
);
    logic base_ok;
    logic sr_locked;

    assign base_ok   = req_valid_i && wel_i && !busy_i;
    assign sr_locked = lock_bit_i && !wp_pin_i;

    // Choose the kind-specific condition on top of the common one.
    always_comb begin
        unique case (kind_i)
            WR_ARRAY:  allow_o = base_ok && !guarded_i;
            WR_STATUS: allow_o = base_ok && !sr_locked;
            default:   allow_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/wps_store.sv
// Status storage: the non-volatile lock and protect bits (flops with reset
// values), a readback shadow that freezes while busy, and the comparison
// and erased flags. Assumes commit_i is only raised for allowed writes.
module wps_store
    import wps_pkg::*;
#(
    parameter logic [SR_W-1:0] SR_INIT = 8'h10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit_i,
    input  logic [SR_W-1:0] wdata_i,
    input  logic            busy_i,
    input  logic            cmp_valid_i,
    input  logic            cmp_lower_i,
    output nv_bits_t        nv_o,
    output nv_bits_t        view_o,
    output logic            cmp_o,
    output logic            erased_o
);
    localparam nv_bits_t NV_INIT = '{lock: SR_INIT[SR_LOCK_POS],
                                     bp:   SR_INIT[SR_BP_HI:SR_BP_LO]};

    nv_bits_t nv_q;
    nv_bits_t view_q;
    logic     cmp_q;
    logic     era_q;

    // Live non-volatile bits: take the writable fields of an allowed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_q <= NV_INIT;
        end else if (commit_i) begin
            nv_q.lock <= wdata_i[SR_LOCK_POS];
            nv_q.bp   <= wdata_i[SR_BP_HI:SR_BP_LO];
        end
    end

    // Readback shadow: follows the live bits only while the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            view_q <= NV_INIT;
        end else if (!busy_i) begin
            view_q <= nv_q;
        end
    end

    // Comparison flag: loaded from the counter comparator when it reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= SR_INIT[SR_CMP_POS];
        end else if (cmp_valid_i) begin
            cmp_q <= cmp_lower_i;
        end
    end

    // Erased flag: holds its reset value in this model.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            era_q <= SR_INIT[SR_ERA_POS];
        end else begin
            era_q <= era_q;
        end
    end

    assign nv_o     = nv_q;
    assign view_o   = view_q;
    assign cmp_o    = cmp_q;
    assign erased_o = era_q;

endmodule

// File: rtl/wps_status_unit.sv
// Top: write-protection and status unit. Decides per request whether an
// array or status write may proceed and presents the status byte.
// Assumes requests come from a decoder that holds them for one cycle.
module wps_status_unit
    import wps_pkg::*;
#(
    parameter int              ADDR_W    = 10,
    parameter int              CNT_BYTES = 32,
    parameter logic [SR_W-1:0] SR_INIT   = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin_i,
    input  logic              req_valid_i,
    input  logic              req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [SR_W-1:0]   req_data_i,
    input  logic              wel_i,
    input  logic              busy_i,
    input  logic              cmp_valid_i,
    input  logic              cmp_lower_i,
    output logic              allow_o,
    output logic [SR_W-1:0]   status_o
);
    wr_kind_e kind;
    nv_bits_t nv_live;
    nv_bits_t nv_view;
    logic     guarded;
    logic     commit;
    logic     cmp_flag;
    logic     era_flag;

    assign kind   = wr_kind_e'(req_kind_i);
    assign commit = allow_o && (kind == WR_STATUS);

    wps_region_dec #(
        .ADDR_W   (ADDR_W),
        .CNT_BYTES(CNT_BYTES)
    ) u_region (
        .bp_i     (nv_live.bp),
        .addr_i   (req_addr_i),
        .guarded_o(guarded)
    );

    wps_gate u_gate (
        .req_valid_i(req_valid_i),
        .kind_i     (kind),
        .wel_i      (wel_i),
        .busy_i     (busy_i),
        .guarded_i  (guarded),
        .lock_bit_i (nv_live.lock),
        .wp_pin_i   (wp_pin_i),
        .allow_o    (allow_o)
    );

    wps_store #(
        .SR_INIT(SR_INIT)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .wdata_i    (req_data_i),
        .busy_i     (busy_i),
        .cmp_valid_i(cmp_valid_i),
        .cmp_lower_i(cmp_lower_i),
        .nv_o       (nv_live),
        .view_o     (nv_view),
        .cmp_o      (cmp_flag),
        .erased_o   (era_flag)
    );

    // Assemble the readback byte: frozen non-volatile bits, live latch/busy.
    always_comb begin
        status_o                     = '0;
        status_o[SR_LOCK_POS]        = nv_view.lock;
        status_o[SR_ERA_POS]         = era_flag;
        status_o[SR_CMP_POS]         = cmp_flag;
        status_o[SR_BP_HI:SR_BP_LO]  = nv_view.bp;
        status_o[SR_WEL_POS]         = wel_i;
        status_o[SR_BSY_POS]         = busy_i;
    end

endmodule

// File: rtl/wps_status_sva.sv
// Checker: temporal properties of the write-protection unit, bound to the
// top module. Observes ports plus the live lock and protect bits.
module wps_status_sva #(
    parameter int ADDR_W    = 10,
    parameter int CNT_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_pin_i,
    input logic              req_valid_i,
    input logic              req_kind_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              wel_i,
    input logic              busy_i,
    input logic              allow_o,
    input logic [7:0]        status_o,
    input logic              nv_lock,
    input logic [1:0]        nv_bp
);
    localparam logic [ADDR_W-1:0] CNT_LIMIT = ADDR_W'(CNT_BYTES);

    AST_NEED_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !wel_i |-> !allow_o); // R4

    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !allow_o); // R4

    AST_LIVE_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[1:0] == {wel_i, busy_i}); // R9

    AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_kind_i && nv_lock && !wp_pin_i) |-> !allow_o); // R6

    AST_COUNTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_kind_i && (req_addr_i < CNT_LIMIT) && wel_i && !busy_i)
            |-> allow_o); // R3

    AST_TOP_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_kind_i && (nv_bp != 2'b00) && (&req_addr_i)) |-> !allow_o); // R2

    AST_FREEZE_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> $stable({status_o[7], status_o[3:2]})); // R8

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid_i && req_kind_i && allow_o) |-> status_o[5] == 1'b0); // R5

endmodule

bind wps_status_unit wps_status_sva #(
    .ADDR_W   (ADDR_W),
    .CNT_BYTES(CNT_BYTES)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_pin_i   (wp_pin_i),
    .req_valid_i(req_valid_i),
    .req_kind_i (req_kind_i),
    .req_addr_i (req_addr_i),
    .wel_i      (wel_i),
    .busy_i     (busy_i),
    .allow_o    (allow_o),
    .status_o   (status_o),
    .nv_lock    (nv_live.lock),
    .nv_bp      (nv_live.bp)
);

// File: tb/wps_status_unit_tb.sv
// Directed bench for the write-protection and status unit.
module wps_status_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_pin_i = 1'b1;
    logic       req_valid_i = 1'b0;
    logic       req_kind_i = 1'b0;
    logic [9:0] req_addr_i = '0;
    logic [7:0] req_data_i = '0;
    logic       wel_i = 1'b0;
    logic       busy_i = 1'b0;
    logic       cmp_valid_i = 1'b0;
    logic       cmp_lower_i = 1'b0;
    logic       allow_o;
    logic [7:0] status_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    wps_status_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wp_pin_i   (wp_pin_i),
        .req_valid_i(req_valid_i),
        .req_kind_i (req_kind_i),
        .req_addr_i (req_addr_i),
        .req_data_i (req_data_i),
        .wel_i      (wel_i),
        .busy_i     (busy_i),
        .cmp_valid_i(cmp_valid_i),
        .cmp_lower_i(cmp_lower_i),
        .allow_o    (allow_o),
        .status_o   (status_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // Present an array write for one cycle and check the decision.
    task automatic try_array(input string req, input logic [9:0] addr, input logic exp);
        @(negedge clk);
        req_valid_i = 1'b1; req_kind_i = 1'b0; req_addr_i = addr;
        #1 check(req, {7'd0, allow_o}, {7'd0, exp});
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    // Present a status write, check the decision, then the readback.
    task automatic try_status(input string req, input logic [7:0] data,
                              input logic exp_allow, input logic [7:0] exp_sr);
        @(negedge clk);
        req_valid_i = 1'b1; req_kind_i = 1'b1; req_data_i = data;
        #1 check(req, {7'd0, allow_o}, {7'd0, exp_allow});
        @(negedge clk);
        req_valid_i = 1'b0;
        @(negedge clk);
        #1 check(req, status_o, exp_sr);
    endtask

    task automatic t_reset;
        @(negedge clk);
        #1 check("R1", status_o, 8'h10);
    endtask

    task automatic t_live_bits;
        @(negedge clk); wel_i = 1'b1;
        #1 check("R9", status_o, 8'h12);
        busy_i = 1'b1;
        #1 check("R9", status_o, 8'h13);
        @(negedge clk); busy_i = 1'b0; wel_i = 1'b0;
        #1 check("R9", status_o, 8'h10);
    endtask

    task automatic t_enable_rules;
        wel_i = 1'b0;
        try_array("R4", 10'h100, 1'b0);
        try_status("R4", 8'h0C, 1'b0, 8'h10);
        @(negedge clk); wel_i = 1'b1; busy_i = 1'b1;
        try_array("R4", 10'h100, 1'b0);
        @(negedge clk); busy_i = 1'b0;
        try_array("R4", 10'h100, 1'b1);
    endtask

    task automatic t_regions;
        try_status("R2", 8'h04, 1'b1, 8'h16);
        try_array("R2", 10'h2FF, 1'b1);
        try_array("R2", 10'h300, 1'b0);
        try_array("R2", 10'h3FF, 1'b0);
        try_array("R3", 10'h010, 1'b1);
        try_status("R2", 8'h08, 1'b1, 8'h1A);
        try_array("R2", 10'h1FF, 1'b1);
        try_array("R2", 10'h200, 1'b0);
        try_status("R2", 8'h0C, 1'b1, 8'h1E);
        try_array("R2", 10'h020, 1'b0);
        try_array("R3", 10'h01F, 1'b1);
        try_array("R3", 10'h000, 1'b1);
        try_status("R2", 8'h00, 1'b1, 8'h12);
        try_array("R2", 10'h3FF, 1'b1);
    endtask

    task automatic t_field_mask;
        try_status("R5", 8'h73, 1'b1, 8'h12);
        try_status("R5", 8'hFF, 1'b1, 8'h9E);
    endtask

    task automatic t_hw_lock;
        @(negedge clk); wp_pin_i = 1'b0;
        try_status("R6", 8'h00, 1'b0, 8'h9E);
        try_array("R6", 10'h100, 1'b0);
        try_array("R3", 10'h005, 1'b1);
        @(negedge clk); wp_pin_i = 1'b1;
        #1 check("R6", status_o, 8'h9E);
        try_status("R6", 8'h80, 1'b1, 8'h92);
    endtask

    task automatic t_soft_mode;
        try_status("R7", 8'h00, 1'b1, 8'h12);
        @(negedge clk); wp_pin_i = 1'b0;
        try_status("R7", 8'h08, 1'b1, 8'h1A);
        try_status("R7", 8'h00, 1'b1, 8'h12);
        @(negedge clk); wp_pin_i = 1'b1;
    endtask

    task automatic t_freeze;
        @(negedge clk);
        req_valid_i = 1'b1; req_kind_i = 1'b1; req_data_i = 8'h84;
        #1 check("R8", {7'd0, allow_o}, 8'h01);
        @(negedge clk);
        req_valid_i = 1'b0; busy_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #1 check("R8", status_o, 8'h13);
        end
        busy_i = 1'b0;
        #1 check("R8", status_o, 8'h12);
        @(negedge clk);
        #1 check("R8", status_o, 8'h96);
        try_status("R8", 8'h00, 1'b1, 8'h12);
    endtask

    task automatic t_cmp_flag;
        @(negedge clk); cmp_valid_i = 1'b1; cmp_lower_i = 1'b0;
        @(negedge clk); cmp_valid_i = 1'b0;
        #1 check("R10", status_o, 8'h02);
        @(negedge clk); cmp_valid_i = 1'b1; cmp_lower_i = 1'b1;
        @(negedge clk); cmp_valid_i = 1'b0;
        #1 check("R10", status_o, 8'h12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_live_bits();
        t_enable_rules();
        t_regions();
        t_field_mask();
        t_hw_lock();
        t_soft_mode();
        t_freeze();
        t_cmp_flag();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule